// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits beside one processor core and decides whether a store-conditional may write memory. A load-reserved request reads a word and records a reservation covering the power-of-two granule that holds its address. A later store-conditional to that granule commits only if nothing has written the granule in between. Writes are detected by address, never by comparing data, so a value that was changed and then put back still makes the store-conditional fail.

Writes seen on the snoop port come from other agents. They kill a reservation whose granule they hit. Local ordinary stores to the granule kill it as well, and so does an exceptional event such as a context switch or an interrupt. A second load-reserved replaces the first, because only one reservation exists. An optional weak mode also kills the reservation on a local ordinary load to the granule. A small word memory behind the request port holds the data, so the pass or fail outcome can be seen as a change in stored data.

Top module: `excl_monitor`

## Requirements
- R1: A load-reserved (`req_op` = 2) returns the addressed word on `rsp_rdata` with `rsp_valid` high one cycle after the request, and records a reservation on the granule of `req_addr`.
- R2: A store-conditional (`req_op` = 3) that succeeds drives `mem_we` high in its request cycle and writes `req_wdata`. A failing one leaves `mem_we` low and memory unchanged.
- R3: Failure is decided by write events alone. A store-conditional fails after an intervening write to the granule even when that write stored the value already present.
- R4: The granule is `GRAIN_BYTES` bytes (a power of two from 8 to 2048), aligned to its size. A write to any byte inside it kills the reservation, and a write outside it has no effect.
- R5: A snooped write (`snoop_valid`) to the reserved granule kills the reservation. A local ordinary store (`req_op` = 1) to that granule kills it too.
- R6: Only one reservation is held. A new load-reserved replaces the earlier one, so a store-conditional to the old granule then fails.
- R7: `excp_event` clears the reservation unconditionally. A store-conditional in the same cycle as `excp_event` fails.
- R8: A store-conditional with no valid reservation, or one whose address is outside the reserved granule, fails.
- R9: Every store-conditional clears the reservation, whether it passes or fails.
- R10: When a snooped write to the granule and a store-conditional arrive in the same cycle, the snoop wins and the store-conditional fails.
- R11: With `WEAK_MODE` = 1, a local ordinary load (`req_op` = 0) to the reserved granule also kills the reservation. With `WEAK_MODE` = 0 such a load has no effect.
- R12: `sc_valid` pulses for exactly one cycle, the cycle after each store-conditional request. `sc_fail` is 0 for success and 1 for failure. Memory is indexed by `req_addr` bits above the byte offset within a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Local request strobe |
| req_op | input | 2 | 0 load, 1 store, 2 load-reserved, 3 store-conditional |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Store data |
| snoop_valid | input | 1 | Another agent writes in this cycle |
| snoop_addr | input | ADDR_W | Byte address of the snooped write |
| excp_event | input | 1 | Exceptional event, clears the reservation |
| mem_we | output | 1 | Memory write enable for this cycle's request |
| rsp_valid | output | 1 | Read data valid (load or load-reserved, one cycle later) |
| rsp_rdata | output | DATA_W | Read data |
| sc_valid | output | 1 | Store-conditional result valid |
| sc_fail | output | 1 | 0 success, 1 failure |

## Verification
Two functions can land in the same cycle: a snooped write that kills the reservation and a local store-conditional that consumes it. The bench drives both in one request cycle, with the snoop aimed at a different byte of the reserved granule. It judges the outcome by `sc_fail` being 1, by `mem_we` staying low, and by a later load returning the old word. A second collision pairs `excp_event` with a store-conditional and is judged the same way.

// File: rtl/excl_pkg.sv
package excl_pkg;
  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_LDRES  = 2'd2,
    OP_STCOND = 2'd3
  } acc_op_e;
endpackage

// File: rtl/word_store.sv
module word_store #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      cells[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_q <= cells[rd_idx];
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/resv_tracker.sv
module resv_tracker #(
  parameter int ADDR_W    = 16,
  parameter int GRAIN_LSB = 6,
  parameter bit WEAK_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lr_go,
  input  logic              sc_go,
  input  logic              ld_go,
  input  logic              st_go,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              excp_event,
  output logic              sc_pass,
  output logic              resv_valid
);
  localparam int TAG_W = ADDR_W - GRAIN_LSB;

  logic [TAG_W-1:0] tag_q, tag_d;
  logic             vld_q, vld_d;
  logic [TAG_W-1:0] req_tag, snp_tag;
  logic             req_hit, snp_hit, snp_on_req, local_kill;

  assign req_tag    = req_addr[ADDR_W-1:GRAIN_LSB];
  assign snp_tag    = snoop_addr[ADDR_W-1:GRAIN_LSB];
  assign req_hit    = vld_q && (req_tag == tag_q);
  assign snp_hit    = vld_q && snoop_valid && (snp_tag == tag_q);
  assign snp_on_req = snoop_valid && (snp_tag == req_tag);

  generate
    if (WEAK_MODE) begin : g_weak
      assign local_kill = req_hit && (st_go || ld_go);
    end else begin : g_strong
      assign local_kill = req_hit && st_go;
    end
  endgenerate

  assign sc_pass = sc_go && req_hit && !snp_hit && !excp_event;

  always_comb begin
    tag_d = tag_q;
    vld_d = vld_q;
    if (excp_event) begin
      vld_d = 1'b0;
    end else if (lr_go) begin
      tag_d = req_tag;
      vld_d = !snp_on_req;
    end else if (sc_go || snp_hit || local_kill) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      tag_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (lr_go) begin
        tag_q <= tag_d;
      end
    end
  end

  assign resv_valid = vld_q;

  assert_excp_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    excp_event |=> !resv_valid);

  assert_sc_consumes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sc_go |=> !resv_valid);

  assert_snoop_kills_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && !lr_go) |=> !resv_valid);

  assert_lr_records_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_go && !excp_event && !snp_on_req) |=> (resv_valid && tag_q == $past(req_tag)));

  assert_pass_needs_resv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sc_pass |-> (resv_valid && !snoop_valid || resv_valid && snp_tag != tag_q));
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int GRAIN_BYTES = 64,
  parameter int MEM_WORDS   = 64,
  parameter bit WEAK_MODE   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              excp_event,
  output logic              mem_we,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sc_valid,
  output logic              sc_fail
);
  localparam int GRAIN_LSB  = $clog2(GRAIN_BYTES);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int WORD_LSB   = $clog2(WORD_BYTES);
  localparam int IDX_W      = $clog2(MEM_WORDS);

  acc_op_e          op;
  logic             lr_go, sc_go, ld_go, st_go, sc_pass, resv_valid;
  logic             rd_go;
  logic [IDX_W-1:0] word_idx;
  logic             rsp_valid_q, rsp_valid_d;
  logic             sc_valid_q, sc_valid_d;
  logic             sc_fail_q, sc_fail_d;

  assign op       = acc_op_e'(req_op);
  assign ld_go    = req_valid && (op == OP_LOAD);
  assign st_go    = req_valid && (op == OP_STORE);
  assign lr_go    = req_valid && (op == OP_LDRES);
  assign sc_go    = req_valid && (op == OP_STCOND);
  assign rd_go    = ld_go || lr_go;
  assign word_idx = req_addr[WORD_LSB +: IDX_W];

  resv_tracker #(
    .ADDR_W   (ADDR_W),
    .GRAIN_LSB(GRAIN_LSB),
    .WEAK_MODE(WEAK_MODE)
  ) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .lr_go      (lr_go),
    .sc_go      (sc_go),
    .ld_go      (ld_go),
    .st_go      (st_go),
    .req_addr   (req_addr),
    .snoop_valid(snoop_valid),
    .snoop_addr (snoop_addr),
    .excp_event (excp_event),
    .sc_pass    (sc_pass),
    .resv_valid (resv_valid)
  );

  assign mem_we = st_go || sc_pass;

  word_store #(
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) u_mem (
    .clk    (clk),
    .wr_en  (mem_we),
    .wr_idx (word_idx),
    .wr_data(req_wdata),
    .rd_en  (rd_go),
    .rd_idx (word_idx),
    .rd_data(rsp_rdata)
  );

  always_comb begin
    rsp_valid_d = rd_go;
    sc_valid_d  = sc_go;
    sc_fail_d   = sc_fail_q;
    if (sc_go) begin
      sc_fail_d = !sc_pass;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      sc_valid_q  <= 1'b0;
      sc_fail_q   <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      sc_valid_q  <= sc_valid_d;
      sc_fail_q   <= sc_fail_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign sc_valid  = sc_valid_q;
  assign sc_fail   = sc_fail_q;

  assert_sc_result_timing_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sc_valid |-> $past(sc_go));

  assert_sc_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && !$past(sc_go, 2)) |=> (sc_valid == $past(sc_go)));

  assert_fail_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && sc_fail) |-> !$past(mem_we));

  assert_collision_fails_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_go && snoop_valid && snoop_addr[ADDR_W-1:GRAIN_LSB] == req_addr[ADDR_W-1:GRAIN_LSB])
      |=> (sc_valid && sc_fail));

  assert_resp_follows_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> rsp_valid);
endmodule

// File: tb/sim_excl_monitor.sv
module sim_excl_monitor;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          snoop_valid = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic          excp_event = 1'b0;

  logic          we0, rv0, sv0, sf0, we1, rv1, sv1, sf1;
  logic [DW-1:0] rd0, rd1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic          c_we0, c_rv0, c_sv0, c_sf0, c_sv1, c_sf1;
  logic [DW-1:0] c_rd0;

  always #2 clk = ~clk;

  excl_monitor #(.ADDR_W(AW), .DATA_W(DW), .GRAIN_BYTES(64), .MEM_WORDS(64), .WEAK_MODE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .excp_event(excp_event), .mem_we(we0), .rsp_valid(rv0), .rsp_rdata(rd0),
    .sc_valid(sv0), .sc_fail(sf0));

  excl_monitor #(.ADDR_W(AW), .DATA_W(DW), .GRAIN_BYTES(64), .MEM_WORDS(64), .WEAK_MODE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .excp_event(excp_event), .mem_we(we1), .rsp_valid(rv1), .rsp_rdata(rd1),
    .sc_valid(sv1), .sc_fail(sf1));

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One request cycle; write enable captured before the edge, registered results after it.
  task automatic drive(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit snp, input logic [AW-1:0] sa, input bit exc);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    snoop_valid = snp; snoop_addr = sa; excp_event = exc;
    #1;
    c_we0 = we0;
    @(posedge clk);
    #1;
    c_rv0 = rv0; c_rd0 = rd0; c_sv0 = sv0; c_sf0 = sf0; c_sv1 = sv1; c_sf1 = sf1;
    @(negedge clk);
    req_valid = 1'b0; snoop_valid = 1'b0; excp_event = 1'b0;
  endtask

  task automatic snoop_only(input logic [AW-1:0] sa);
    @(negedge clk);
    snoop_valid = 1'b1; snoop_addr = sa;
    @(negedge clk);
    snoop_valid = 1'b0;
  endtask

  task automatic excp_only();
    @(negedge clk);
    excp_event = 1'b1;
    @(negedge clk);
    excp_event = 1'b0;
  endtask

  task automatic t_reset();
    chk(rv0 == 1'b0, "R1 rsp_valid after reset", rv0, 0);
    chk(sv0 == 1'b0, "R12 sc_valid after reset", sv0, 0);
    drive(2'd3, 16'h0010, 32'h1, 0, 0, 0);
    chk(c_we0 == 1'b0, "R8 no-reservation write enable", c_we0, 0);
    chk(c_sv0 && c_sf0, "R8 no-reservation sc fails", {c_sv0, c_sf0}, 2'b11);
    @(posedge clk); #1;
    chk(sv0 == 1'b0, "R12 sc_valid one-cycle pulse", sv0, 0);
  endtask

  task automatic t_basic();
    drive(2'd1, 16'h0010, 32'hAAAA0001, 0, 0, 0);
    drive(2'd2, 16'h0010, 0, 0, 0, 0);
    chk(c_rv0 && c_rd0 == 32'hAAAA0001, "R1 load-reserved data", c_rd0, 32'hAAAA0001);
    drive(2'd3, 16'h0010, 32'hBBBB0002, 0, 0, 0);
    chk(c_we0 == 1'b1, "R2 pass write enable", c_we0, 1);
    chk(c_sv0 && !c_sf0, "R2 sc passes", {c_sv0, c_sf0}, 2'b10);
    drive(2'd0, 16'h0010, 0, 0, 0, 0);
    chk(c_rd0 == 32'hBBBB0002, "R2 memory written", c_rd0, 32'hBBBB0002);
  endtask

  task automatic t_aba();
    drive(2'd2, 16'h0020, 0, 0, 0, 0);
    snoop_only(16'h003C);
    drive(2'd3, 16'h0020, 32'h5, 0, 0, 0);
    chk(c_sf0 == 1'b1, "R5 snoop same granule kills", c_sf0, 1);
    chk(c_we0 == 1'b0, "R2 failed sc no write enable", c_we0, 0);
    drive(2'd0, 16'h0020, 0, 0, 0, 0);
    chk(c_rd0 != 32'h5, "R2 failed sc memory unchanged", c_rd0, 0);
    drive(2'd1, 16'h0024, 32'h77, 0, 0, 0);
    drive(2'd2, 16'h0024, 0, 0, 0, 0);
    drive(2'd1, 16'h0024, 32'h77, 0, 0, 0);
    drive(2'd3, 16'h0024, 32'h78, 0, 0, 0);
    chk(c_sf0 == 1'b1, "R3 same-value store still kills", c_sf0, 1);
  endtask

  task automatic t_granule();
    drive(2'd2, 16'h0020, 0, 0, 0, 0);
    snoop_only(16'h0040);
    drive(2'd1, 16'h0080, 32'h9, 0, 0, 0);
    drive(2'd3, 16'h0030, 32'h6, 0, 0, 0);
    chk(c_sv0 && !c_sf0, "R4 outside writes ignored, other byte of granule passes", c_sf0, 0);
    drive(2'd2, 16'h0040, 0, 0, 0, 0);
    drive(2'd3, 16'h0080, 32'h6, 0, 0, 0);
    chk(c_sf0 == 1'b1, "R8 sc outside reserved granule", c_sf0, 1);
  endtask

  task automatic t_replace();
    drive(2'd2, 16'h0010, 0, 0, 0, 0);
    drive(2'd2, 16'h0080, 0, 0, 0, 0);
    drive(2'd3, 16'h0010, 32'h1, 0, 0, 0);
    chk(c_sf0 == 1'b1, "R6 old reservation replaced", c_sf0, 1);
    drive(2'd2, 16'h0010, 0, 0, 0, 0);
    drive(2'd2, 16'h0080, 0, 0, 0, 0);
    drive(2'd3, 16'h00BC, 32'h2, 0, 0, 0);
    chk(c_sf0 == 1'b0, "R6 new reservation holds", c_sf0, 0);
    drive(2'd3, 16'h00BC, 32'h3, 0, 0, 0);
    chk(c_sf0 == 1'b1, "R9 second sc after pass fails", c_sf0, 1);
  endtask

  task automatic t_excp();
    drive(2'd2, 16'h0010, 0, 0, 0, 0);
    excp_only();
    drive(2'd3, 16'h0010, 32'h1, 0, 0, 0);
    chk(c_sf0 == 1'b1, "R7 event clears reservation", c_sf0, 1);
    drive(2'd2, 16'h0010, 0, 0, 0, 0);
    drive(2'd3, 16'h0010, 32'h1, 0, 0, 1);
    chk(c_sf0 == 1'b1 && c_we0 == 1'b0, "R7 event with sc fails", {c_sf0, c_we0}, 2'b10);
    drive(2'd2, 16'h0010, 0, 0, 0, 0);
    drive(2'd3, 16'h0050, 32'h1, 0, 0, 0);
    drive(2'd3, 16'h0010, 32'h1, 0, 0, 0);
    chk(c_sf0 == 1'b1, "R9 failed sc also clears", c_sf0, 1);
  endtask

  task automatic t_collide();
    drive(2'd1, 16'h0100, 32'hC0DE0000, 0, 0, 0);
    drive(2'd2, 16'h0100, 0, 0, 0, 0);
    drive(2'd3, 16'h0100, 32'hDEAD0000, 1, 16'h0108, 0);
    chk(c_sv0 && c_sf0, "R10 snoop beats same-cycle sc", {c_sv0, c_sf0}, 2'b11);
    chk(c_we0 == 1'b0, "R10 no write on collision", c_we0, 0);
    drive(2'd0, 16'h0100, 0, 0, 0, 0);
    chk(c_rd0 == 32'hC0DE0000, "R10 memory keeps old word", c_rd0, 32'hC0DE0000);
  endtask

  task automatic t_weak();
    drive(2'd2, 16'h0010, 0, 0, 0, 0);
    drive(2'd0, 16'h0014, 0, 0, 0, 0);
    drive(2'd3, 16'h0010, 32'h1, 0, 0, 0);
    chk(c_sv0 && !c_sf0, "R11 strong mode load ignored", c_sf0, 0);
    chk(c_sv1 && c_sf1, "R11 weak mode load kills", c_sf1, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_basic();
    t_aba();
    t_granule();
    t_replace();
    t_excp();
    t_collide();
    t_weak();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule